// File: doc/BRIEF.md
# Wake Event Latch Unit

This block collects wake events for a power controller. It watches a parameterised set of wake sources, which can be external pins or internal interrupt lines. Each source passes through a two-flop synchroniser. An edge of the direction programmed for that source is then captured in a sticky raw event record. The record captures events whether or not the source is enabled for wake. Software clears it by writing ones.

A per-source enable register gates the raw record into a masked view. When any masked bit is set, a small two-state machine raises a wake request to the power sequencer. The machine sits in `WK_IDLE` while no masked bit is set and moves to `WK_REQ` on the first cycle that one is set. It returns from `WK_REQ` to `WK_IDLE` on the first cycle that none is set. Software reaches four registers through a single-cycle write port and a combinational read port.

Top module: `wake_event_latch`

## Requirements
- R1: After reset, every enable bit is 0, the raw record is 0, the masked view is 0, wake_req is low and the polarity register holds the parameter POL_RESET.
- R2: A polarity bit of 1 makes its source latch on a 0-to-1 change, and a polarity bit of 0 makes it latch on a 1-to-0 change. A change in the other direction latches nothing.
- R3: The raw record captures a qualifying edge even when that source's enable bit is 0.
- R4: Writing to the raw record clears every bit whose write-data bit is 1. Bits written with 0 keep their value, and a bit falls only through such a write.
- R5: If a qualifying edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: The masked view reads as raw record AND enable. It is read-only, so a write to its address changes no register.
- R7: wake_req goes high on the clock edge after the masked view becomes nonzero, and it goes low on the clock edge after the masked view becomes zero.
- R8: A change on src_i that is driven before clock edge E1 appears in the raw record after edge E3: two synchroniser stages, then the latch.
- R9: The register address map is 0 enable (read/write), 1 polarity (read/write), 2 masked view (read-only), 3 raw record (read, write 1 to clear).
- R10: A source held at a steady level produces no new event after its bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous wake source lines |
| reg_wr | input | 1 | Register write strobe, taken on the rising clock edge |
| reg_addr | input | 2 | Register select (see R9) |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Combinational read data for reg_addr |
| wake_req | output | 1 | Wake request to the power sequencer |

## Verification
Two functions can land on the same cycle: a synchronised edge setting a raw bit, and a software write clearing that bit. The bench raises a source line and waits until the detected edge is due on the following clock. It then presents a raw-record write that clears both that bit and an older set bit, timed to the same edge. A correct result keeps the new bit set and drops the older one. A second overlap places an enable write one cycle before a masked change. Reading wake_req on each side of the edge shows the one-cycle lag of the wake state machine.

// File: rtl/wel_pkg.sv
package wel_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE   = 2'd0,
        REG_POLARITY = 2'd1,
        REG_MASKED   = 2'd2,
        REG_RAW      = 2'd3
    } wel_reg_e;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_REQ  = 1'b1
    } wel_wake_e;

endpackage

// File: rtl/wel_sync.sv
module wel_sync #(
    parameter int          NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] IDLE_LVL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] async_i,
    output logic [NUM_SRC-1:0] sync_o
);

    logic [NUM_SRC-1:0] stage1_q;
    logic [NUM_SRC-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= IDLE_LVL;
            stage2_q <= IDLE_LVL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/wel_edge.sv
module wel_edge #(
    parameter int          NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] IDLE_LVL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_i,
    input  logic [NUM_SRC-1:0] pol_i,
    output logic [NUM_SRC-1:0] hit_o
);

    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= IDLE_LVL;
        end else begin
            prev_q <= sync_i;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic rise_w;
        logic fall_w;
        assign rise_w   = sync_i[i] & ~prev_q[i];
        assign fall_w   = ~sync_i[i] & prev_q[i];
        assign hit_o[i] = pol_i[i] ? rise_w : fall_w;
    end

endmodule

// File: rtl/wel_regs.sv
module wel_regs
    import wel_pkg::*;
#(
    parameter int          NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] POL_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] hit_i,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] pol_q,
    output logic [NUM_SRC-1:0] raw_q,
    output logic [NUM_SRC-1:0] masked_o,
    output logic [NUM_SRC-1:0] rdata
);

    wel_reg_e           sel;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] raw_d;

    assign sel      = wel_reg_e'(addr);
    assign clr_mask = (wr_en && sel == REG_RAW) ? wdata : '0;
    assign raw_d    = (raw_q & ~clr_mask) | hit_i;   // new edge wins over clear
    assign masked_o = raw_q & en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= POL_RESET;
            raw_q <= '0;
        end else begin
            raw_q <= raw_d;
            if (wr_en && sel == REG_ENABLE) begin
                en_q <= wdata;
            end
            if (wr_en && sel == REG_POLARITY) begin
                pol_q <= wdata;
            end
        end
    end

    always_comb begin
        unique case (sel)
            REG_ENABLE:   rdata = en_q;
            REG_POLARITY: rdata = pol_q;
            REG_MASKED:   rdata = masked_o;
            REG_RAW:      rdata = raw_q;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/wel_wake_fsm.sv
module wel_wake_fsm
    import wel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic wake_o
);

    wel_wake_e state_q;
    wel_wake_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE: if (any_i)  state_d = WK_REQ;
            WK_REQ:  if (!any_i) state_d = WK_IDLE;
            default: state_d = WK_IDLE;
        endcase
    end

    always_comb begin
        wake_o = (state_q == WK_REQ);
    end

endmodule

// File: rtl/wake_event_latch.sv
module wake_event_latch
    import wel_pkg::*;
#(
    parameter int          NUM_SRC   = 32,
    parameter logic [NUM_SRC-1:0] POL_RESET = 32'h0000_0007,
    parameter logic [NUM_SRC-1:0] IDLE_LVL  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               wake_req
);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] edge_hit;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] masked;

    wel_sync #(.NUM_SRC(NUM_SRC), .IDLE_LVL(IDLE_LVL)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    wel_edge #(.NUM_SRC(NUM_SRC), .IDLE_LVL(IDLE_LVL)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (src_sync),
        .pol_i  (pol_q),
        .hit_o  (edge_hit)
    );

    wel_regs #(.NUM_SRC(NUM_SRC), .POL_RESET(POL_RESET)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .hit_i    (edge_hit),
        .en_q     (en_q),
        .pol_q    (pol_q),
        .raw_q    (raw_q),
        .masked_o (masked),
        .rdata    (reg_rdata)
    );

    wel_wake_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .any_i  (|masked),
        .wake_o (wake_req)
    );

endmodule

// File: rtl/wel_checker.sv
module wel_checker #(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         addr,
    input logic [NUM_SRC-1:0] wdata,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] hit,
    input logic               wake
);

    logic [NUM_SRC-1:0] clr_seen;
    logic               any_masked;

    assign clr_seen   = (wr_en && addr == 2'd3) ? wdata : '0;
    assign any_masked = |(raw_q & en_q);

    // R1: state right after reset release
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_q == '0 && raw_q == '0 && !wake));

    // R4: a raw bit only falls where a clearing write had a 1
    assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~raw_q & $past(raw_q) & ~$past(clr_seen)) == '0));

    // R5: a detected edge always leaves its bit set, clear or not
    assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((raw_q & $past(hit)) == $past(hit)));

    // R6: writes to the masked view touch no enable bit
    assert_masked_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> $stable(en_q));

    // R7: wake follows the masked view by one cycle
    assert_wake_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_masked |=> wake);

    assert_wake_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !any_masked |=> !wake);

endmodule

bind wake_event_latch wel_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .en_q  (en_q),
    .raw_q (raw_q),
    .hit   (edge_hit),
    .wake  (wake_req)
);

// File: tb/tb_wake_event_latch.sv
module tb_wake_event_latch;

    localparam int        CLK_PERIOD = 10;
    localparam int        N          = 8;
    localparam logic [N-1:0] POL_DEF = 8'hC0;

    // {polarity, enable, src_a, src_b, expected raw, expected masked}
    localparam logic [47:0] VEC [6] = '{
        {8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h0F, 8'h0F},
        {8'h00, 8'hFF, 8'hFF, 8'hF0, 8'h0F, 8'h0F},
        {8'hFF, 8'h00, 8'h00, 8'hAA, 8'hAA, 8'h00},
        {8'h0F, 8'hF0, 8'hF0, 8'h0F, 8'hFF, 8'hF0},
        {8'hF0, 8'hFF, 8'hF0, 8'h0F, 8'h00, 8'h00},
        {8'h55, 8'h0F, 8'h00, 8'hFF, 8'h55, 8'h05}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_i = '0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         wake_req;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_event_latch #(.NUM_SRC(N), .POL_RESET(POL_DEF)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wake_req  (wake_req)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R9: reset values through the address map
        read_reg(2'd0, rd); check("R1 enable", rd, 8'h00);
        read_reg(2'd1, rd); check("R9 polarity", rd, POL_DEF);
        read_reg(2'd2, rd); check("R1 masked", rd, 8'h00);
        read_reg(2'd3, rd); check("R1 raw", rd, 8'h00);
        check("R1 wake", {7'd0, wake_req}, 8'h00);

        // table walk: R2, R3, R6
        for (int i = 0; i < 6; i++) begin
            logic [47:0] v;
            v = VEC[i];
            write_reg(2'd1, v[47:40]);
            write_reg(2'd0, v[39:32]);
            src_i = v[31:24];
            repeat (5) @(negedge clk);
            write_reg(2'd3, 8'hFF);
            src_i = v[23:16];
            repeat (5) @(negedge clk);
            read_reg(2'd3, rd); check("R2 R3 raw row", rd, v[15:8]);
            read_reg(2'd2, rd); check("R6 masked row", rd, v[7:0]);
            check("R7 wake row", {7'd0, wake_req}, {7'd0, |v[7:0]});
        end

        // R8: latency of three edges
        write_reg(2'd1, 8'hFF);
        write_reg(2'd0, 8'h00);
        src_i = 8'h00;
        repeat (5) @(negedge clk);
        write_reg(2'd3, 8'hFF);
        src_i[0] = 1'b1;
        @(negedge clk); read_reg(2'd3, rd); check("R8 after E1", rd, 8'h00);
        @(negedge clk); read_reg(2'd3, rd); check("R8 after E2", rd, 8'h00);
        @(negedge clk); read_reg(2'd3, rd); check("R8 after E3", rd, 8'h01);

        // R5: edge on bit1 meets a clear of bits 1 and 0 on the same edge
        src_i[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h03;
        @(negedge clk);
        reg_wr = 1'b0;
        read_reg(2'd3, rd); check("R5 collision", rd, 8'h02);

        // R4: zeros written leave bits alone
        write_reg(2'd3, 8'h00);
        read_reg(2'd3, rd); check("R4 zero write", rd, 8'h02);

        // R10: steady level after clear
        write_reg(2'd3, 8'h02);
        repeat (6) @(negedge clk);
        read_reg(2'd3, rd); check("R10 steady", rd, 8'h00);

        // R3: disabled source still latches, no wake
        src_i[2] = 1'b1;
        repeat (5) @(negedge clk);
        read_reg(2'd3, rd); check("R3 raw disabled", rd, 8'h04);
        check("R3 no wake", {7'd0, wake_req}, 8'h00);

        // R7: enable write then one-cycle wake lag
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R7 wake lag", {7'd0, wake_req}, 8'h00);
        read_reg(2'd2, rd); check("R6 masked", rd, 8'h04);
        @(negedge clk);
        check("R7 wake set", {7'd0, wake_req}, 8'h01);

        // R6: write to masked address ignored
        write_reg(2'd2, 8'h00);
        read_reg(2'd0, rd); check("R6 enable kept", rd, 8'h04);
        read_reg(2'd2, rd); check("R6 masked kept", rd, 8'h04);

        // R7: clear then one-cycle wake drop
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R7 wake hold", {7'd0, wake_req}, 8'h01);
        @(negedge clk);
        check("R7 wake drop", {7'd0, wake_req}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule